// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives a debugger direct reach into system memory. The debugger talks to it through a small bank of 32-bit registers: one control register, four address words and four data words. Bus transactions are never started by a dedicated command. They are side effects of register traffic. A write to the low address word can launch a read. A read of the low data word can launch the next read. A write to the low data word launches a write.

Accesses of 8, 16, 32 and 64 bits are supported, up to a width fixed by a parameter. The address is held as a 128-bit quantity in four 32-bit words. It can step forward by the access size after each access, carrying through all four words. The low 64 address bits drive the memory port. That port is a plain request/response interface: the request is held until an acknowledge arrives, and the acknowledge carries the read data and a fault flag. Problems are reported in a sticky error field that software clears by writing ones to it.

Top module: `sysbus_access_master`

## Requirements
- R1: After reset, the control register (index 0) reads 0x2040_3C00 with the default 64-bit maximum width. This value holds version 1 in bits [31:29], an address width of 64 in bits [22:16], the supported-size flags for 64/32/16/8 bits in bits [13:10], and zeros elsewhere. After reset, `mem_req` is low and all address and data words read 0.
- R2: Writing address word 0 (index 1) while read-on-address (control bit 4) is set and no error is pending issues one read request on the next cycle. That request carries the new address and the size code from control bits [2:0].
- R3: Read data is stored according to the size code. Code 0 keeps byte [7:0] of the response in data word 0 (index 5), code 1 keeps [15:0], and code 2 keeps [31:0]. In each of these cases the upper bits of data word 0 are zero and data word 1 (index 6) is unchanged. Code 3 stores the low half of the response in data word 0 and the high half in data word 1.
- R4: Writing data word 0 with no error pending issues a write request whose write data is {data word 1, data word 0}. When the acknowledge arrives without a fault and auto-increment (control bit 3) is set, the address advances by 2^size bytes.
- R5: A read of data word 0 returns its value before the access. If no error is pending, the same read also advances the address when auto-increment is set. If read-on-data (control bit 5) is also set, it then issues a read at the advanced address.
- R6: The address increment is a 128-bit addition over address words 0 to 3 (indices 1 to 4), with carries passing from word to word.
- R7: An access whose size code exceeds log2(maximum width / 8) issues no request and sets error code 3 in control bits [8:6].
- R8: An acknowledge with the fault flag set sets error code 2. In that case the data words and the address are left unchanged.
- R9: The error field is write-1-to-clear: each 1 written to control bits [8:6] clears that error bit. Writing 0 to those bits leaves them unchanged.
- R10: While the error field is nonzero, none of the three register triggers issues a request.
- R11: Control bit 9 reads 1 while a request is outstanding. During that time, any write to an address or data word, or any read of data word 0, has no effect and sets error code 4 if no error is pending. The request's address, size and direction stay stable until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register index: 0 control, 1-4 address words, 5-8 data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 64 | Low 64 bits of the access address |
| mem_size | output | 3 | Size code, bytes = 2^code |
| mem_wdata | output | 64 | Write data {data word 1, data word 0} |
| mem_ack | input | 1 | Response for the held request |
| mem_rdata | input | 64 | Read response data |
| mem_fault | input | 1 | Response is a bus fault |

## Verification
The bench walks the address across 32-bit word boundaries at two sizes. A design that dropped the carry between words would leave the upper words stale and raise no other symptom. It also reads data word 0 with read-on-data and auto-increment together. This catches a design that launches the next read from the old address or returns the freshly fetched value instead of the previous one. Register pokes made while a request is outstanding, partial write-1-to-clear patterns, and faults on both directions make sure a wrong design cannot corrupt the address, lose sticky errors or bump the address after a failed write without being reported.

// File: rtl/sysbus_access_master.sv
module sysbus_access_master #(
  parameter int MAX_BITS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [2:0]  mem_size,
  output logic [63:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata,
  input  logic        mem_fault
);
  localparam int MAX_CODE = $clog2(MAX_BITS / 8);
  localparam logic [2:0] E_FAULT = 3'd2;
  localparam logic [2:0] E_SIZE  = 3'd3;
  localparam logic [2:0] E_BUSY  = 3'd4;

  logic [2:0]        size_q;
  logic              inc_q, roa_q, rod_q;
  logic [2:0]        err_q;
  logic              busy_q, we_q;
  logic [3:0][31:0]  addr_q;
  logic [3:0][31:0]  data_q;
  logic [3:0]        sup;

  for (genvar i = 0; i < 4; i++) begin : g_sup
    assign sup[i] = (MAX_BITS >= (8 << i));
  end

  wire        wr       = reg_valid & reg_write;
  wire        rd       = reg_valid & ~reg_write;
  wire [1:0]  widx     = reg_addr[1:0] - 2'd1;
  wire        sel_addr = (reg_addr >= 4'd1) && (reg_addr <= 4'd4);
  wire        sel_data = (reg_addr >= 4'd5) && (reg_addr <= 4'd8);
  wire        trig_a   = wr && reg_addr == 4'd1;
  wire        trig_w   = wr && reg_addr == 4'd5;
  wire        trig_r   = rd && reg_addr == 4'd5;
  wire        no_err   = (err_q == 3'd0);
  wire        start_wr = trig_w && no_err;
  wire        start_rd = ((trig_a && roa_q) || (trig_r && rod_q)) && no_err;
  wire        size_ok  = size_q <= 3'(MAX_CODE);
  wire [127:0] step    = 128'(1) << size_q;
  wire [127:0] addr_inc = addr_q + step;
  wire        busy_hit = (wr && (sel_addr || sel_data)) || trig_r;

  wire [31:0] ctl = {3'd1, 6'd0, 7'd64, 2'd0, sup[3], sup[2], sup[1], sup[0],
                     busy_q, err_q, rod_q, roa_q, inc_q, size_q};

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == 4'd0) reg_rdata = ctl;
    else if (sel_addr)    reg_rdata = addr_q[widx];
    else if (sel_data)    reg_rdata = data_q[widx];
  end

  assign mem_req   = busy_q;
  assign mem_we    = we_q;
  assign mem_size  = size_q;
  assign mem_addr  = {addr_q[1], addr_q[0]};
  assign mem_wdata = {data_q[1], data_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0; inc_q <= 1'b0; roa_q <= 1'b0; rod_q <= 1'b0;
      err_q  <= '0; busy_q <= 1'b0; we_q <= 1'b0;
      addr_q <= '0; data_q <= '0;
    end else begin
      if (busy_q) begin
        if (wr && reg_addr == 4'd0) err_q <= err_q & ~reg_wdata[8:6];
        else if (busy_hit && no_err) err_q <= E_BUSY;
      end else begin
        if (wr && reg_addr == 4'd0) begin
          size_q <= reg_wdata[2:0];
          inc_q  <= reg_wdata[3];
          roa_q  <= reg_wdata[4];
          rod_q  <= reg_wdata[5];
          err_q  <= err_q & ~reg_wdata[8:6];
        end
        if (wr && sel_addr) addr_q[widx] <= reg_wdata;
        if (wr && sel_data) data_q[widx] <= reg_wdata;
        if (trig_r && no_err && inc_q) addr_q <= addr_inc;
        if (start_wr || start_rd) begin
          if (size_ok) begin
            busy_q <= 1'b1;
            we_q   <= start_wr;
          end else begin
            err_q  <= E_SIZE;
          end
        end
      end

      if (busy_q && mem_ack) begin
        busy_q <= 1'b0;
        if (mem_fault) begin
          if (no_err) err_q <= E_FAULT;
        end else if (we_q) begin
          if (inc_q) addr_q <= addr_inc;
        end else begin
          case (size_q)
            3'd0:    data_q[0] <= {24'd0, mem_rdata[7:0]};
            3'd1:    data_q[0] <= {16'd0, mem_rdata[15:0]};
            3'd2:    data_q[0] <= mem_rdata[31:0];
            default: begin
              data_q[0] <= mem_rdata[31:0];
              data_q[1] <= mem_rdata[63:32];
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sysbus_access_master_chk.sv
module sysbus_access_master_chk #(
  parameter int MAX_BITS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [3:0]  reg_addr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [2:0]  mem_size,
  input logic        mem_ack,
  input logic        mem_fault,
  input logic [2:0]  err_q
);
  localparam int MAX_CODE = $clog2(MAX_BITS / 8);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we)));

  p_req_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size <= 3'(MAX_CODE)));

  p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_fault && err_q == 3'd0) |=> (err_q == 3'd2));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 3'd0 && !(reg_valid && reg_write && reg_addr == 4'd0)) |=> $stable(err_q));

  p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && err_q != 3'd0) |=> !mem_req);
endmodule

bind sysbus_access_master sysbus_access_master_chk #(.MAX_BITS(MAX_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_size(mem_size), .mem_ack(mem_ack), .mem_fault(mem_fault), .err_q(err_q)
);

// File: tb/sysbus_access_master_tb_top.sv
`timescale 1ns/1ps
module sysbus_access_master_tb_top;
  localparam int LAT = 6;
  localparam logic [31:0] BASE = 32'h2040_3C00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, mem_fault;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0] mem_size;

  int n_checks = 0, n_fail = 0;
  logic        q_we[$];
  logic [63:0] q_addr[$];
  logic [2:0]  q_size[$];
  logic [63:0] q_wd[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  sysbus_access_master #(.MAX_BITS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault)
  );

  function automatic logic [63:0] model(input logic [63:0] a);
    return {a[31:0] ^ 32'hC3C3_0F0F, a[31:0] + 32'h0101_0101};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_req(input string tag, input logic we, input logic [63:0] a,
                            input logic [2:0] sz, input logic [63:0] wd);
    q_tag.push_back(tag); q_we.push_back(we); q_addr.push_back(a);
    q_size.push_back(sz); q_wd.push_back(wd);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_rd(a, v);
    chk(tag, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  // responder and scoreboard monitor
  initial begin
    int cnt;
    bit seen;
    cnt = 0; seen = 0;
    mem_ack = 1'b0; mem_fault = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (!mem_req || !rst_n) begin
        seen = 0; cnt = 0;
      end else begin
        if (!seen) begin
          seen = 1;
          if (q_we.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL unexpected request: got addr %h we %0d expected none", mem_addr, mem_we);
          end else begin
            string t;
            logic e_we; logic [63:0] e_a, e_wd; logic [2:0] e_sz;
            t = q_tag.pop_front(); e_we = q_we.pop_front(); e_a = q_addr.pop_front();
            e_sz = q_size.pop_front(); e_wd = q_wd.pop_front();
            chk({t, " dir"}, {63'd0, mem_we}, {63'd0, e_we});
            chk({t, " addr"}, mem_addr, e_a);
            chk({t, " size"}, {61'd0, mem_size}, {61'd0, e_sz});
            if (e_we) chk({t, " wdata"}, mem_wdata, e_wd);
          end
        end
        cnt++;
        if (cnt == LAT) begin
          mem_ack = 1'b1;
          mem_fault = (mem_addr[15:12] == 4'hE);
          mem_rdata = model(mem_addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    rd_chk("R1 control", 4'd0, BASE);
    rd_chk("R1 addr0", 4'd1, 32'd0);
    rd_chk("R1 data0", 4'd5, 32'd0);

    // R2 read on address, 32-bit; R3 data1 untouched
    reg_wr(4'd0, 32'h12);
    expect_req("R2 read", 1'b0, 64'h1000, 3'd2, 64'd0);
    reg_wr(4'd1, 32'h1000);
    wait_idle;
    rd_chk("R2 data0", 4'd5, 32'h0101_1101);
    rd_chk("R3 data1 kept", 4'd6, 32'd0);

    // R3 byte and halfword placement
    reg_wr(4'd6, 32'hDEAD_BEEF);
    reg_wr(4'd0, 32'h10);
    expect_req("R3 byte read", 1'b0, 64'h2003, 3'd0, 64'd0);
    reg_wr(4'd1, 32'h2003);
    wait_idle;
    rd_chk("R3 byte data0", 4'd5, 32'h04);
    rd_chk("R3 byte data1", 4'd6, 32'hDEAD_BEEF);
    reg_wr(4'd0, 32'h11);
    expect_req("R3 half read", 1'b0, 64'h2002, 3'd1, 64'd0);
    reg_wr(4'd1, 32'h2002);
    wait_idle;
    rd_chk("R3 half data0", 4'd5, 32'h2103);
    reg_wr(4'd0, 32'h13);
    expect_req("R3 dword read", 1'b0, 64'h3000, 3'd3, 64'd0);
    reg_wr(4'd1, 32'h3000);
    wait_idle;
    rd_chk("R3 dword data0", 4'd5, 32'h0101_3101);
    rd_chk("R3 dword data1", 4'd6, 32'hC3C3_3F0F);

    // R4 write on data with increment
    reg_wr(4'd0, 32'h0B);
    reg_wr(4'd1, 32'h4000);
    reg_wr(4'd6, 32'h1234_5678);
    expect_req("R4 write", 1'b1, 64'h4000, 3'd3, 64'h1234_5678_9ABC_DEF0);
    reg_wr(4'd5, 32'h9ABC_DEF0);
    wait_idle;
    rd_chk("R4 addr0 stepped", 4'd1, 32'h4008);

    // R6 carries
    reg_wr(4'd0, 32'h0A);
    reg_wr(4'd2, 32'h1);
    reg_wr(4'd1, 32'hFFFF_FFFC);
    expect_req("R6 write", 1'b1, 64'h1_FFFF_FFFC, 3'd2, 64'h1234_5678_1111_1111);
    reg_wr(4'd5, 32'h1111_1111);
    wait_idle;
    rd_chk("R6 addr0", 4'd1, 32'd0);
    rd_chk("R6 addr1", 4'd2, 32'd2);
    reg_wr(4'd0, 32'h08);
    reg_wr(4'd4, 32'd5);
    reg_wr(4'd3, 32'hFFFF_FFFF);
    reg_wr(4'd2, 32'hFFFF_FFFF);
    reg_wr(4'd1, 32'hFFFF_FFFF);
    expect_req("R6 byte write", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 64'h1234_5678_0000_0022);
    reg_wr(4'd5, 32'h22);
    wait_idle;
    rd_chk("R6 ripple addr0", 4'd1, 32'd0);
    rd_chk("R6 ripple addr2", 4'd3, 32'd0);
    rd_chk("R6 ripple addr3", 4'd4, 32'd6);

    // R5 read on data
    reg_wr(4'd4, 32'd0);
    reg_wr(4'd0, 32'h2A);
    reg_wr(4'd1, 32'h5000);
    expect_req("R5 read 1", 1'b0, 64'h5004, 3'd2, 64'd0);
    rd_chk("R5 old data0", 4'd5, 32'h22);
    wait_idle;
    rd_chk("R5 addr0", 4'd1, 32'h5004);
    expect_req("R5 read 2", 1'b0, 64'h5008, 3'd2, 64'd0);
    rd_chk("R5 fetched data0", 4'd5, 32'h0101_5105);
    wait_idle;
    reg_wr(4'd0, 32'h02);
    rd_chk("R5 second fetch", 4'd5, 32'h0101_5109);
    rd_chk("R5 addr0 again", 4'd1, 32'h5008);

    // R7 oversize, R10 blocked, R9 clear
    reg_wr(4'd0, 32'h14);
    reg_wr(4'd1, 32'h6000);
    rd_chk("R7 size error", 4'd0, BASE | 32'hD4);
    reg_wr(4'd0, 32'h12);
    reg_wr(4'd1, 32'h6100);
    repeat (LAT + 2) @(negedge clk);
    rd_chk("R10 error kept, no request", 4'd0, BASE | 32'hD2);
    reg_wr(4'd0, 32'h52);
    rd_chk("R9 partial clear", 4'd0, BASE | 32'h92);
    reg_wr(4'd0, 32'h1D2);
    rd_chk("R9 full clear", 4'd0, BASE | 32'h12);

    // R8 faults
    reg_wr(4'd0, 32'h0A);
    reg_wr(4'd1, 32'hE000);
    expect_req("R8 write", 1'b1, 64'hE000, 3'd2, 64'h1234_5678_5555_AAAA);
    reg_wr(4'd5, 32'h5555_AAAA);
    wait_idle;
    rd_chk("R8 write fault code", 4'd0, BASE | 32'h8A);
    rd_chk("R8 addr0 not stepped", 4'd1, 32'hE000);
    reg_wr(4'd0, 32'h1D2);
    expect_req("R8 read", 1'b0, 64'hE010, 3'd2, 64'd0);
    reg_wr(4'd1, 32'hE010);
    wait_idle;
    rd_chk("R8 read fault code", 4'd0, BASE | 32'h92);
    rd_chk("R8 data0 kept", 4'd5, 32'h5555_AAAA);
    reg_wr(4'd0, 32'h1D2);

    // R11 busy
    expect_req("R11 read", 1'b0, 64'h7000, 3'd2, 64'd0);
    reg_wr(4'd1, 32'h7000);
    rd_chk("R11 busy bit", 4'd0, BASE | 32'h212);
    reg_wr(4'd1, 32'h7100);
    wait_idle;
    rd_chk("R11 busy error", 4'd0, BASE | 32'h112);
    rd_chk("R11 addr0 kept", 4'd1, 32'h7000);
    rd_chk("R11 data0", 4'd5, 32'h0101_7101);

    chk("R2 all expected requests seen", 64'(q_we.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule